// File: doc/BRIEF.md
# Three-Die Roller with Rejection Sampling

This block rolls three six-sided dice for a push-button game. While the player holds the button, a pseudo-random generator steps once per clock. When the player lets go, the block picks one value per die and shows each value on its own seven-segment display. It also drives the face values as binary numbers and gives a one-cycle strobe each time a new result is stored.

Each die reads a 3-bit code from the generator. Codes 0 to 5 give faces 1 to 6, and codes 6 and 7 are rejected. On release, the result is stored only on a cycle where all three codes are legal at once. If any code is illegal, the generator keeps stepping until one such cycle arrives. This avoids the bias that folding eight codes onto six faces would cause.

The generator restarts from the same seed after every reset, so the only randomness is the player's timing. A parameter replaces the generator with three cascaded mod-6 counters. These counters visit all 216 combinations in order.

The controller is a four-state machine:
- `ST_BLANK` is the state after reset, with all displays dark.
- `ST_ROLL` is entered from `ST_BLANK` or `ST_SHOW` when the synchronized button is high.
- `ST_SETTLE` is entered from `ST_ROLL` on release when the current codes are not all legal.
- `ST_SHOW` is entered from `ST_ROLL` on release with legal codes, or from `ST_SETTLE` on the first legal cycle.

Top module: `dice_roller`

## Requirements
- R1: After reset, `face0`..`face2` are 0, all segment buses are 7'b0000000 (blank) and `done` is 0. This holds until the first roll completes.
- R2: Die k takes code bits [3k+2:3k] of the generator state and shows face code+1. A result is stored only when all three codes are below 6.
- R3: With the default mode, the generator is a 16-bit register with reset value 16'hACE1. Each step shifts it left and inserts bit15^bit13^bit12^bit10 at bit 0. An all-zero state reloads 16'hACE1.
- R4: The raw button passes through two flip-flops. Suppose the button is first high at clock edge 1 and is held for H edges. Then the generator steps at edges 4 through H+2, which is H-1 steps. Release is detected at edge H+3.
- R5: At release, if the codes are legal, the result is stored at that edge and the generator holds. Otherwise the generator steps once per edge until the first legal state, which is stored without a further step. With s illegal states skipped, the result appears after edge H+3+s.
- R6: `done` is high for exactly one cycle, in the cycle after the result is stored, and the faces are non-zero while it is high.
- R7: Faces and segments change only when `done` rises. The generator does not step between rolls, so the next roll continues from the stored state.
- R8: Segments are active high, ordered {g,f,e,d,c,b,a}. The patterns are: 1=0000110, 2=1011011, 3=1001111, 4=1100110, 5=1101101, 6=1111101, blank=0000000.
- R9: With `COUNTER_MODE`=1, die 0 is a mod-6 counter that steps as in R4. Each counter carries into the next when it wraps from 5 to 0. No code is ever illegal, so s is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| btn_raw | input | 1 | Unsynchronized roll button, high while held |
| seg0 | output | 7 | Die 0 segments {g,f,e,d,c,b,a} |
| seg1 | output | 7 | Die 1 segments |
| seg2 | output | 7 | Die 2 segments |
| face0 | output | 3 | Die 0 face 1..6, 0 when blank |
| face1 | output | 3 | Die 1 face |
| face2 | output | 3 | Die 2 face |
| done | output | 1 | One-cycle strobe when new faces are stored |

## Verification
The hardest path to reach is `ST_SETTLE`. It needs the release to land on a generator state with an illegal code, and the number of extra steps depends on the state sequence that follows. The bench sweeps the hold length from 1 to 60 cycles over back-to-back rolls. For each roll it steps its own model of the polynomial to predict whether settling occurs and how many states are skipped. It then checks the exact cycle of `done` and the stored faces. A second instance in counter mode runs in the same sweep, checking the carry chain across many positions of the 216-value cycle.

// File: rtl/dice_pkg.sv
package dice_pkg;
    localparam int DIE_N    = 3;
    localparam int CODE_W   = 3;
    localparam int FIELD_W  = DIE_N * CODE_W;
    localparam int SEG_W    = 7;
    localparam int FACE_TOP = 6;

    typedef enum logic [1:0] {
        ST_BLANK,
        ST_ROLL,
        ST_SETTLE,
        ST_SHOW
    } roll_state_t;
endpackage

// File: rtl/dice_sync.sv
module dice_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic level,
    output logic fall
);
    logic [STAGES-1:0] chain;
    logic              level_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            chain   <= '0;
            level_q <= 1'b0;
        end else begin
            chain   <= {chain[STAGES-2:0], din};
            level_q <= chain[STAGES-1];
        end
    end

    assign level = chain[STAGES-1];
    assign fall  = level_q & ~chain[STAGES-1];
endmodule

// File: rtl/dice_gen.sv
module dice_gen
    import dice_pkg::*;
#(
    parameter bit          COUNTER_MODE = 1'b0,
    parameter int          LFSR_W       = 16,
    parameter logic [15:0] SEED         = 16'hACE1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               step,
    output logic [FIELD_W-1:0] fields
);
    generate
        if (COUNTER_MODE == 1'b0) begin : g_lfsr
            logic [LFSR_W-1:0] sr;
            logic              fb;
            assign fb = sr[15] ^ sr[13] ^ sr[12] ^ sr[10];
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n)
                    sr <= LFSR_W'(SEED);
                else if (sr == '0)
                    sr <= LFSR_W'(SEED);
                else if (step)
                    sr <= {sr[LFSR_W-2:0], fb};
            end
            assign fields = sr[FIELD_W-1:0];
        end else begin : g_cnt
            logic [DIE_N:0] carry;
            assign carry[0] = step;
            for (genvar d = 0; d < DIE_N; d++) begin : g_die
                logic [CODE_W-1:0] cnt;
                logic              wrap;
                assign wrap = (cnt == CODE_W'(FACE_TOP - 1));
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n)
                        cnt <= '0;
                    else if (carry[d])
                        cnt <= wrap ? '0 : cnt + 1'b1;
                end
                assign carry[d+1] = carry[d] & wrap;
                assign fields[d*CODE_W +: CODE_W] = cnt;
            end
        end
    endgenerate
endmodule

// File: rtl/dice_seg.sv
module dice_seg
    import dice_pkg::*;
(
    input  logic [CODE_W-1:0] face,
    output logic [SEG_W-1:0]  seg
);
    always_comb begin
        unique case (face)
            3'd1:    seg = 7'b0000110;
            3'd2:    seg = 7'b1011011;
            3'd3:    seg = 7'b1001111;
            3'd4:    seg = 7'b1100110;
            3'd5:    seg = 7'b1101101;
            3'd6:    seg = 7'b1111101;
            default: seg = 7'b0000000;
        endcase
    end
endmodule

// File: rtl/dice_roller.sv
module dice_roller
    import dice_pkg::*;
#(
    parameter bit          COUNTER_MODE = 1'b0,
    parameter logic [15:0] SEED         = 16'hACE1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             btn_raw,
    output logic [SEG_W-1:0] seg0,
    output logic [SEG_W-1:0] seg1,
    output logic [SEG_W-1:0] seg2,
    output logic [2:0]       face0,
    output logic [2:0]       face1,
    output logic [2:0]       face2,
    output logic             done
);
    roll_state_t        state, state_nx;
    logic               btn_lvl, btn_fall;
    logic               legal, capture, advance;
    logic [FIELD_W-1:0] fields;
    logic [CODE_W-1:0]  face_q [DIE_N];
    logic [SEG_W-1:0]   seg_w  [DIE_N];

    dice_sync #(.STAGES(2)) u_sync (
        .clk(clk), .rst_n(rst_n), .din(btn_raw),
        .level(btn_lvl), .fall(btn_fall)
    );

    dice_gen #(.COUNTER_MODE(COUNTER_MODE), .LFSR_W(16), .SEED(SEED)) u_gen (
        .clk(clk), .rst_n(rst_n), .step(advance), .fields(fields)
    );

    always_comb begin
        legal = 1'b1;
        for (int d = 0; d < DIE_N; d++)
            if (fields[d*CODE_W +: CODE_W] >= CODE_W'(FACE_TOP))
                legal = 1'b0;
    end

    assign capture = ((state == ST_ROLL) && btn_fall && legal) ||
                     ((state == ST_SETTLE) && legal);
    assign advance = ((state == ST_ROLL) && !capture) ||
                     ((state == ST_SETTLE) && !legal);

    always_comb begin
        state_nx = state;
        unique case (state)
            ST_BLANK, ST_SHOW: if (btn_lvl) state_nx = ST_ROLL;
            ST_ROLL:           if (btn_fall) state_nx = legal ? ST_SHOW : ST_SETTLE;
            ST_SETTLE:         if (legal) state_nx = ST_SHOW;
            default:           state_nx = ST_BLANK;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_BLANK;
        else        state <= state_nx;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            done <= 1'b0;
            for (int d = 0; d < DIE_N; d++) face_q[d] <= '0;
        end else begin
            done <= capture;
            if (capture)
                for (int d = 0; d < DIE_N; d++)
                    face_q[d] <= fields[d*CODE_W +: CODE_W] + 1'b1;
        end
    end

    generate
        for (genvar d = 0; d < DIE_N; d++) begin : g_disp
            dice_seg u_seg (.face(face_q[d]), .seg(seg_w[d]));
        end
    endgenerate

    assign face0 = face_q[0];
    assign face1 = face_q[1];
    assign face2 = face_q[2];
    assign seg0  = seg_w[0];
    assign seg1  = seg_w[1];
    assign seg2  = seg_w[2];
endmodule

// File: rtl/dice_roller_chk.sv
module dice_roller_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       btn_raw,
    input logic [6:0] seg0,
    input logic [6:0] seg1,
    input logic [6:0] seg2,
    input logic [2:0] face0,
    input logic [2:0] face1,
    input logic [2:0] face2,
    input logic       done
);
    // R6: strobe lasts one cycle
    a_r6_done_single: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R6: stored faces are real faces when strobed
    a_r6_done_faces: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (face0 != 3'd0 && face1 != 3'd0 && face2 != 3'd0));

    // R2: faces stay in 0..6
    a_r2_face_range: assert property (@(posedge clk) disable iff (!rst_n)
        (face0 <= 3'd6) && (face1 <= 3'd6) && (face2 <= 3'd6));

    // R7: faces move only with the strobe
    a_r7_faces_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !done |-> ($stable(face0) && $stable(face1) && $stable(face2)));

    // R8: blank display exactly when face is zero
    a_r8_blank_zero: assert property (@(posedge clk) disable iff (!rst_n)
        ((face0 == 3'd0) == (seg0 == 7'd0)) &&
        ((face1 == 3'd0) == (seg1 == 7'd0)) &&
        ((face2 == 3'd0) == (seg2 == 7'd0)));

    // R8: a lit digit uses at least two segments
    a_r8_lit_count: assert property (@(posedge clk) disable iff (!rst_n)
        (face0 != 3'd0) |-> ($countones(seg0) >= 2));
endmodule

bind dice_roller dice_roller_chk u_chk (.*);

// File: tb/dice_roller_test.sv
module dice_roller_test;
    localparam int CLK_PERIOD = 10;
    localparam logic [15:0] SEED = 16'hACE1;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic btn = 1'b0;
    logic [6:0] sa0, sa1, sa2, sb0, sb1, sb2;
    logic [2:0] fa0, fa1, fa2, fb0, fb1, fb2;
    logic       da, db;

    int n_chk = 0;
    int n_bad = 0;
    bit finished = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    dice_roller #(.COUNTER_MODE(1'b0), .SEED(SEED)) uut (
        .clk(clk), .rst_n(rst_n), .btn_raw(btn),
        .seg0(sa0), .seg1(sa1), .seg2(sa2),
        .face0(fa0), .face1(fa1), .face2(fa2), .done(da));

    dice_roller #(.COUNTER_MODE(1'b1), .SEED(SEED)) uut_ctr (
        .clk(clk), .rst_n(rst_n), .btn_raw(btn),
        .seg0(sb0), .seg1(sb1), .seg2(sb2),
        .face0(fb0), .face1(fb1), .face2(fb2), .done(db));

    function automatic logic [15:0] nxt(input logic [15:0] s);
        if (s == 16'd0) return SEED;
        return {s[14:0], s[15] ^ s[13] ^ s[12] ^ s[10]};
    endfunction

    function automatic bit ok3(input logic [15:0] s);
        return (s[2:0] < 3'd6) && (s[5:3] < 3'd6) && (s[8:6] < 3'd6);
    endfunction

    function automatic logic [6:0] pat(input int f);
        case (f)
            1: return 7'b0000110;
            2: return 7'b1011011;
            3: return 7'b1001111;
            4: return 7'b1100110;
            5: return 7'b1101101;
            6: return 7'b1111101;
            default: return 7'b0000000;
        endcase
    endfunction

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s act=%0d exp=%0d", tag, act, exp);
        end
    endtask

    logic [15:0] m_st = SEED;
    int          m_idx = 0;

    task automatic roll(input int h);
        logic [15:0] st;
        int s, ka, kb, na, nb;
        int ea0, ea1, ea2, eb0, eb1, eb2;
        int pa0, pb0;
        st = m_st;
        for (int i = 0; i < h - 1; i++) st = nxt(st);
        s = 0;
        while (!ok3(st)) begin st = nxt(st); s++; end
        m_st = st;
        m_idx = (m_idx + h - 1) % 216;
        ea0 = int'(st[2:0]) + 1; ea1 = int'(st[5:3]) + 1; ea2 = int'(st[8:6]) + 1;
        eb0 = m_idx % 6 + 1; eb1 = (m_idx / 6) % 6 + 1; eb2 = (m_idx / 36) % 6 + 1;
        pa0 = int'(fa0); pb0 = int'(fb0);
        btn = 1'b1;
        for (int i = 0; i < h; i++) @(negedge clk);
        // R7: faces held while rolling
        chk(int'(fa0) == pa0 && int'(fb0) == pb0, "R7 hold during roll", int'(fa0), pa0);
        btn = 1'b0;
        ka = -1; kb = -1; na = 0; nb = 0;
        for (int k = 1; k <= 3 + s + 4; k++) begin
            @(negedge clk);
            if (da) begin na++; if (ka < 0) ka = k; end
            if (db) begin nb++; if (kb < 0) kb = k; end
        end
        // R4 R5: strobe timing, includes settle steps
        chk(ka == 3 + s, (s > 0) ? "R5 settle latency" : "R4 release latency", ka, 3 + s);
        chk(na == 1, "R6 single strobe", na, 1);
        // R2 R3: faces from polynomial model
        chk(int'(fa0) == ea0 && int'(fa1) == ea1 && int'(fa2) == ea2, "R2 R3 faces",
            int'({fa2, fa1, fa0}), (ea2 << 6) | (ea1 << 3) | ea0);
        // R8: segment patterns
        chk(sa0 == pat(ea0) && sa1 == pat(ea1) && sa2 == pat(ea2), "R8 segments",
            int'(sa0), int'(pat(ea0)));
        // R9: counter mode
        chk(kb == 3 && nb == 1, "R9 counter latency", kb, 3);
        chk(int'(fb0) == eb0 && int'(fb1) == eb1 && int'(fb2) == eb2 &&
            sb0 == pat(eb0) && sb1 == pat(eb1) && sb2 == pat(eb2), "R9 counter faces",
            int'({fb2, fb1, fb0}), (eb2 << 6) | (eb1 << 3) | eb0);
        for (int i = 0; i < 3; i++) @(negedge clk);
        // R7: faces persist after strobe
        chk(int'(fa0) == ea0 && int'(fb0) == eb0, "R7 hold after roll", int'(fa0), ea0);
    endtask

    initial begin
        repeat (4) @(negedge clk);
        // R1: reset state
        chk(fa0 == 0 && fa1 == 0 && fa2 == 0 && fb0 == 0, "R1 faces zero", int'(fa0), 0);
        chk(sa0 == 0 && sa1 == 0 && sa2 == 0 && sb0 == 0, "R1 blank", int'(sa0), 0);
        chk(!da && !db, "R1 done low", int'(da), 0);
        rst_n = 1'b1;
        repeat (5) @(negedge clk);
        // R1: stays blank without a roll
        chk(fa0 == 0 && sa0 == 0 && !da, "R1 idle blank", int'(sa0), 0);
        for (int h = 1; h <= 60; h++) roll(h);
        for (int h = 50; h <= 120; h += 7) roll(h);
        finished = 1'b1;
    end

    initial begin
        int cyc = 0;
        while (!finished && cyc < 100000) begin
            @(posedge clk);
            cyc++;
        end
        if (!finished) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog act=%0d exp=%0d", cyc, 0);
        end
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end
endmodule